// File: doc/BRIEF.md
# Quad-SPI Flash Read Engine

This block is the read side of a serial-flash slave. It watches a chip select and a serial clock, shifts in an 8-bit command, and serves three read flavours from a small parameterized byte array: a single-lane fast read, a quad-output read and a quad-I/O read. Program, erase and register writes live in other logic. That logic tells this block through a `busy` input that an operation is in flight.

Both quad reads carry a mode byte. If its top bit is clear, the slave stays in a continuous-read mode. Every later transaction then begins directly with a quad-lane address and has no command byte, until a mode byte with the top bit set takes the slave back to ordinary command decoding.

All pins are oversampled by the system clock `clk`:
- `spi_sck` rising edges are detected and used to sample input bits.
- Output lanes are updated after a detected falling edge.

The controller is one state machine. Its states are:
- ST_IDLE: chip select high.
- ST_CMD: command byte.
- ST_FR_ADDR and ST_FR_DUMMY: fast-read address and dummy phases.
- ST_QO_ADDR and ST_QO_DUMMY: quad-output address and dummy phases.
- ST_QI_ADDR and ST_QI_MODE: quad-lane address and mode phases, shared by the quad-I/O read and continuous read.
- ST_DATA1 and ST_DATA4: single-lane and quad-lane data.
- ST_INVALID: unknown command.

Its transitions are:
- Chip select falling: ST_IDLE goes to ST_CMD, or to ST_QI_ADDR when continuous mode is set.
- End of the command byte: ST_CMD goes to one of the three address states, or to ST_INVALID.
- End of each address phase: the address state goes to its dummy or mode state.
- End of each dummy or mode phase: ST_FR_DUMMY goes to ST_DATA1, and ST_QO_DUMMY and ST_QI_MODE go to ST_DATA4.
- Chip select high: every state returns to ST_IDLE.

Top module: `qspi_read_engine`

## Requirements
- R1: After reset, and whenever chip select is high, all output enables are low. The bit count and shift registers restart at the beginning of each transaction.
- R2: Outside continuous mode, the first 8 bits after chip select falls form the command, received on lane 0 MSB first. 0x0B selects fast read, 0x6B selects quad-output read and 0xEB selects quad-I/O read.
- R3: Fast read works as follows:
  - A 24-bit address is received on lane 0, MSB first, and completes at count 32.
  - 8 dummy clocks follow.
  - From count 40, data bytes are driven MSB first on lane 1 with output enable pattern 4'b0010.
  - The address advances by one after each byte.
- R4: Quad-output read (0x6B) works as follows:
  - The address is received on lane 0 and completes at count 32.
  - 32 single-lane dummy clocks follow. The first of them carries the mode flag.
  - From count 64, data is driven on lanes 3..0, high nibble first, with output enable pattern 4'b1111.
- R5: Quad-I/O read (0xEB) works as follows:
  - The address arrives on lanes 3..0, one nibble per clock, high nibble first, over 6 clocks, reaching count 32.
  - 8 quad clocks follow. Lane 3 of the first of them is the mode flag.
  - Quad data is driven from count 64.
- R6: When chip select rises, the next transaction depends on the mode flag:
  - If a quad read received a mode flag of 0, the next transaction is in continuous mode.
  - A flag of 1 returns the slave to command decoding.
  - A transaction that ends before the flag is received also returns the slave to command decoding.
- R7: In continuous mode there is no command byte:
  - The quad address completes at count 24 (6 clocks).
  - 8 quad mode/dummy clocks follow, reaching count 56, and are treated like the quad-I/O read's.
  - Quad data follows.
- R8: Every latched address is taken modulo MEM_BYTES. Incrementing past the last byte wraps to 0.
- R9: While `busy` is high when a byte is fetched, that byte is driven as 0x00 and the address does not advance.
- R10: An unrecognized command byte makes the slave ignore the rest of the transaction with all outputs disabled. The next transaction decodes normally.
- R11: Inputs are sampled on rising SCK edges. Output lanes change only after a falling SCK edge. Output enables stay low in all command, address, dummy and mode phases.
- R12: Array byte `a` holds `(a*37 + SEED) mod 256`. With the defaults, MEM_BYTES = 256 and SEED = 92.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_csn | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock, idle low |
| dq_i | input | 4 | Input values of the four data lanes |
| dq_o | output | 4 | Output values of the four data lanes |
| dq_oe | output | 4 | Per-lane output enables |
| busy | input | 1 | High while a program or erase is in progress |

## Verification
Every result is due at a fixed point relative to the serial clock:
- An input bit is captured on the first `clk` edge that sees `spi_sck` high.
- Each output bit appears one `clk` edge after `spi_sck` is seen low, and is therefore valid for the whole low half of the next serial cycle.
- The first data bit follows the falling edge that comes after the last header rising edge.

The bench holds each SCK half-period for four `clk` cycles. It reads the lanes three and a half `clk` cycles after SCK falls, just before it raises SCK again, so each sample lands on a settled value. `busy` is changed only before the final clock of a byte, so that the falling edge which fetches the next byte sees the intended level.

// File: rtl/qspi_rd_pkg.sv
package qspi_rd_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CMD,
        ST_FR_ADDR,
        ST_FR_DUMMY,
        ST_QO_ADDR,
        ST_QO_DUMMY,
        ST_QI_ADDR,
        ST_QI_MODE,
        ST_DATA1,
        ST_DATA4,
        ST_INVALID
    } rd_state_e;

    localparam logic [7:0] OP_FAST_RD = 8'h0B;
    localparam logic [7:0] OP_QUAD_OUT = 8'h6B;
    localparam logic [7:0] OP_QUAD_IO = 8'hEB;

    localparam int CNT_W = 7;
    localparam int ADR_BITS = 24;

endpackage

// File: rtl/qspi_pin_edges.sv
module qspi_pin_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic csn,
    input  logic sck,
    output logic csn_q,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_rise
);
    logic sck_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            csn_q <= 1'b1;
        end else begin
            sck_q <= sck;
            csn_q <= csn;
        end
    end

    always_comb begin
        sck_rise = !csn && sck && !sck_q;
        sck_fall = !csn && !sck && sck_q;
        cs_rise  = csn && !csn_q;
    end
endmodule

// File: rtl/qspi_pattern_array.sv
module qspi_pattern_array #(
    parameter int MEM_BYTES = 256,
    parameter int SEED      = 92
) (
    input  logic [$clog2(MEM_BYTES)-1:0] addr,
    output logic [7:0]                   rd_byte
);
    logic [7:0] cells [MEM_BYTES];

    for (genvar i = 0; i < MEM_BYTES; i++) begin : g_cell
        assign cells[i] = 8'(i * 37 + SEED);
    end

    assign rd_byte = cells[addr];
endmodule

// File: rtl/qspi_out_shifter.sv
module qspi_out_shifter (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_active,
    input  logic       sck_fall,
    input  logic       data_en,
    input  logic       quad,
    input  logic [7:0] rd_byte,
    input  logic       busy,
    output logic [3:0] dq_o,
    output logic [3:0] dq_oe,
    output logic       take
);
    logic [2:0] sub;
    logic [7:0] hold;
    logic       fetch;
    logic [7:0] src;

    always_comb begin
        fetch = sck_fall && data_en && (sub == 3'd0);
        take  = fetch && !busy;
        src   = busy ? 8'h00 : rd_byte;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sub   <= '0;
            hold  <= '0;
            dq_o  <= '0;
            dq_oe <= '0;
        end else if (!cs_active) begin
            sub   <= '0;
            hold  <= '0;
            dq_o  <= '0;
            dq_oe <= '0;
        end else if (sck_fall && data_en) begin
            dq_oe <= quad ? 4'b1111 : 4'b0010;
            if (sub == 3'd0) begin
                if (quad) begin
                    dq_o <= src[7:4];
                    hold <= {src[3:0], 4'b0};
                    sub  <= 3'd1;
                end else begin
                    dq_o <= {2'b00, src[7], 1'b0};
                    hold <= {src[6:0], 1'b0};
                    sub  <= 3'd7;
                end
            end else begin
                if (quad) begin
                    dq_o <= hold[7:4];
                    hold <= {hold[3:0], 4'b0};
                end else begin
                    dq_o <= {2'b00, hold[7], 1'b0};
                    hold <= {hold[6:0], 1'b0};
                end
                sub <= sub - 3'd1;
            end
        end
    end

    AST_BUSY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch && busy) |=> (dq_o == 4'b0000)); // R9

    AST_DQ_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(dq_o) && cs_active) |-> $past(sck_fall)); // R11
endmodule

// File: rtl/qspi_read_engine.sv
module qspi_read_engine
    import qspi_rd_pkg::*;
#(
    parameter int MEM_BYTES = 256,
    parameter int SEED      = 92
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       spi_csn,
    input  logic       spi_sck,
    input  logic [3:0] dq_i,
    output logic [3:0] dq_o,
    output logic [3:0] dq_oe,
    input  logic       busy
);
    localparam int ADDR_W = $clog2(MEM_BYTES);

    rd_state_e              state, state_nx;
    logic [CNT_W-1:0]       cnt, cnt_nx, base;
    logic [ADR_BITS-1:0]    sreg, sreg_nx;
    logic [ADDR_W-1:0]      addr;
    logic                   flag, flag_seen, xip, xip_start;
    logic                   csn_q, sck_rise, sck_fall, cs_rise;
    logic                   hdr_state, quad_in, addr_done, flag_pt, flag_bit;
    logic                   data_en, quad_out, take;
    logic [7:0]             rd_byte;

    qspi_pin_edges u_edges (
        .clk(clk), .rst_n(rst_n), .csn(spi_csn), .sck(spi_sck),
        .csn_q(csn_q), .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_rise(cs_rise)
    );

    qspi_pattern_array #(.MEM_BYTES(MEM_BYTES), .SEED(SEED)) u_array (
        .addr(addr), .rd_byte(rd_byte)
    );

    qspi_out_shifter u_shift (
        .clk(clk), .rst_n(rst_n), .cs_active(!spi_csn), .sck_fall(sck_fall),
        .data_en(data_en), .quad(quad_out), .rd_byte(rd_byte), .busy(busy),
        .dq_o(dq_o), .dq_oe(dq_oe), .take(take)
    );

    // Phase decode used by the counter, the shifter and the assertions.
    always_comb begin
        hdr_state = (state == ST_CMD)     || (state == ST_FR_ADDR) ||
                    (state == ST_FR_DUMMY) || (state == ST_QO_ADDR) ||
                    (state == ST_QO_DUMMY) || (state == ST_QI_ADDR) ||
                    (state == ST_QI_MODE);
        quad_in   = (state == ST_QI_ADDR) || (state == ST_QI_MODE);
        data_en   = (state == ST_DATA1) || (state == ST_DATA4);
        quad_out  = (state == ST_DATA4);
        base      = xip_start ? 7'd0 : 7'd8;
        cnt_nx    = cnt + (quad_in ? 7'd4 : 7'd1);
        sreg_nx   = quad_in ? {sreg[ADR_BITS-5:0], dq_i} : {sreg[ADR_BITS-2:0], dq_i[0]};
        flag_pt   = ((state == ST_QO_DUMMY) && (cnt == 7'd32)) ||
                    ((state == ST_QI_MODE) && (cnt == base + 7'd24));
        flag_bit  = (state == ST_QO_DUMMY) ? dq_i[0] : dq_i[3];
    end

    // Next-state logic.
    always_comb begin
        state_nx  = state;
        addr_done = 1'b0;
        unique case (state)
            ST_IDLE:     state_nx = xip ? ST_QI_ADDR : ST_CMD;
            ST_CMD: if (sck_rise && cnt_nx == 7'd8) begin
                unique case (sreg_nx[7:0])
                    OP_FAST_RD:  state_nx = ST_FR_ADDR;
                    OP_QUAD_OUT: state_nx = ST_QO_ADDR;
                    OP_QUAD_IO:  state_nx = ST_QI_ADDR;
                    default:     state_nx = ST_INVALID;
                endcase
            end
            ST_FR_ADDR: if (sck_rise && cnt_nx == 7'd32) begin
                state_nx  = ST_FR_DUMMY;
                addr_done = 1'b1;
            end
            ST_FR_DUMMY: if (sck_rise && cnt_nx == 7'd40) state_nx = ST_DATA1;
            ST_QO_ADDR: if (sck_rise && cnt_nx == 7'd32) begin
                state_nx  = ST_QO_DUMMY;
                addr_done = 1'b1;
            end
            ST_QO_DUMMY: if (sck_rise && cnt_nx == 7'd64) state_nx = ST_DATA4;
            ST_QI_ADDR: if (sck_rise && cnt_nx == base + 7'd24) begin
                state_nx  = ST_QI_MODE;
                addr_done = 1'b1;
            end
            ST_QI_MODE: if (sck_rise && cnt_nx == base + 7'd56) state_nx = ST_DATA4;
            ST_DATA1, ST_DATA4, ST_INVALID: state_nx = state;
            default:     state_nx = ST_INVALID;
        endcase
    end

    // State register and transaction bookkeeping.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            sreg      <= '0;
            addr      <= '0;
            flag      <= 1'b0;
            flag_seen <= 1'b0;
            xip       <= 1'b0;
            xip_start <= 1'b0;
        end else if (spi_csn) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            sreg      <= '0;
            flag_seen <= 1'b0;
            if (cs_rise) xip <= flag_seen && !flag;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE) xip_start <= xip;
            if (sck_rise && hdr_state) begin
                cnt  <= cnt_nx;
                sreg <= sreg_nx;
            end
            if (sck_rise && flag_pt) begin
                flag      <= flag_bit;
                flag_seen <= 1'b1;
            end
            if (addr_done) addr <= sreg_nx[ADDR_W-1:0];
            else if (take) addr <= addr + 1'b1;
        end
    end

    AST_OE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        csn_q |-> (dq_oe == 4'b0000)); // R1

    AST_HDR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_state |-> (dq_oe == 4'b0000)); // R11

    AST_INVALID_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_INVALID) |-> (dq_oe == 4'b0000)); // R10

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !spi_csn) |=> (addr == $past(addr) + 1'b1)); // R3
endmodule

// File: tb/tb_qspi_read_engine.sv
module tb_qspi_read_engine;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_csn = 1'b1;
    logic       spi_sck = 1'b0;
    logic [3:0] dq_i = 4'b0;
    logic [3:0] dq_o, dq_oe;
    logic       busy = 1'b0;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;
    logic [3:0] last_do, last_oe;
    logic       hdr_bad;
    logic       oe_bad;
    logic [7:0] got [8];

    always #2 clk = ~clk;

    qspi_read_engine dut (
        .clk(clk), .rst_n(rst_n), .spi_csn(spi_csn), .spi_sck(spi_sck),
        .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe), .busy(busy)
    );

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles, expected completion", cycles);
            summary();
            $finish;
        end
    end

    function automatic logic [7:0] exp_byte(input int a);
        return 8'((a % 256) * 37 + 92); // R12
    endfunction

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic sck_edge(input logic [3:0] din);
        @(negedge clk);
        dq_i = din;
        repeat (3) @(negedge clk);
        last_do = dq_o;
        last_oe = dq_oe;
        spi_sck = 1'b1;
        repeat (4) @(negedge clk);
        spi_sck = 1'b0;
    endtask

    task automatic cs_begin();
        @(negedge clk);
        spi_csn = 1'b0;
        hdr_bad = 1'b0;
        oe_bad = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic cs_end();
        repeat (2) @(negedge clk);
        spi_csn = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic send_bits(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            sck_edge({3'b000, v[i]});
            if (last_oe != 4'b0) hdr_bad = 1'b1;
        end
    endtask

    task automatic send_nib(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            sck_edge(v[4*i +: 4]);
            if (last_oe != 4'b0) hdr_bad = 1'b1;
        end
    endtask

    // Collect n bytes; the first busy_bytes fetches see busy high.
    task automatic collect(input int n, input logic quad, input int busy_bytes);
        int per;
        logic [7:0] b;
        per = quad ? 2 : 8;
        for (int k = 0; k < n; k++) begin
            b = 8'h00;
            for (int j = 0; j < per; j++) begin
                if (j == per - 1) busy = (k + 1 < busy_bytes);
                sck_edge(4'b0);
                if (quad) b = {b[3:0], last_do};
                else b = {b[6:0], last_do[1]};
                if (last_oe != (quad ? 4'b1111 : 4'b0010)) oe_bad = 1'b1;
            end
            got[k] = b;
        end
        busy = 1'b0;
    endtask

    task automatic check_bytes(input int a, input int n, input string req);
        for (int k = 0; k < n; k++)
            check(got[k] == exp_byte(a + k), req, got[k], exp_byte(a + k));
    endtask

    task automatic fast_read(input logic [23:0] a, input int n, input int busy_bytes);
        busy = (busy_bytes > 0);
        cs_begin();
        send_bits(32'h0B, 8);
        send_bits({8'h0, a}, 24);
        send_bits(32'h0, 8);
        collect(n, 1'b0, busy_bytes);
        cs_end();
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check(dq_oe == 4'b0, "R1 reset oe", dq_oe, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(dq_oe == 4'b0 && dq_o == 4'b0, "R1 idle outputs", {dq_oe, dq_o}, 0);
    endtask

    task automatic t_fast();
        fast_read(24'h000010, 4, 0);
        check(!hdr_bad, "R11 fast header oe low", hdr_bad, 0);
        check(!oe_bad, "R3 fast oe pattern 0010", oe_bad, 0);
        check_bytes(16, 4, "R3 fast data");
        check(dq_oe == 4'b0, "R1 oe low after csn high", dq_oe, 0);
    endtask

    task automatic t_mask();
        fast_read(24'hABCDFE, 3, 0);
        check_bytes(254, 3, "R8 masked address and wrap");
    endtask

    task automatic t_busy();
        fast_read(24'h000040, 4, 2);
        check(got[0] == 8'h00 && got[1] == 8'h00, "R9 busy bytes zero", {got[0], got[1]}, 0);
        check(got[2] == exp_byte(64), "R9 address held while busy", got[2], exp_byte(64));
        check(got[3] == exp_byte(65), "R9 advance after busy", got[3], exp_byte(65));
    endtask

    task automatic t_quad_out(input logic [23:0] a, input logic flg);
        cs_begin();
        send_bits(32'h6B, 8);
        send_bits({8'h0, a}, 24);
        send_bits({flg, 31'h0}, 32);
        collect(4, 1'b1, 0);
        cs_end();
        check(!hdr_bad, "R4 header oe low", hdr_bad, 0);
        check(!oe_bad, "R4 oe pattern 1111", oe_bad, 0);
        check_bytes(a, 4, "R4 quad-output data");
    endtask

    task automatic t_quad_io(input logic [23:0] a, input logic flg);
        cs_begin();
        send_bits(32'hEB, 8);
        send_nib({8'h0, a}, 6);
        send_nib({flg, 31'h0}, 8);
        collect(3, 1'b1, 0);
        cs_end();
        check(!hdr_bad && !oe_bad, "R5 oe phases", {hdr_bad, oe_bad}, 0);
        check_bytes(a, 3, "R5 quad-io data");
    endtask

    task automatic t_xip(input logic [23:0] a, input logic flg);
        cs_begin();
        send_nib({8'h0, a}, 6);
        send_nib({flg, 31'h0}, 8);
        collect(3, 1'b1, 0);
        cs_end();
        check(!hdr_bad && !oe_bad, "R7 continuous oe phases", {hdr_bad, oe_bad}, 0);
        check_bytes(a, 3, "R7 continuous-read data");
    endtask

    task automatic t_invalid();
        cs_begin();
        send_bits(32'h9F, 8);
        send_bits(32'hFFFFFFFF, 32);
        send_bits(32'hFF, 8);
        sck_edge(4'b0);
        cs_end();
        check(!hdr_bad, "R10 invalid command outputs off", hdr_bad, 0);
        fast_read(24'h000005, 2, 0);
        check_bytes(5, 2, "R10 next transaction decodes");
    endtask

    task automatic t_abort_xip();
        t_quad_io(24'h000030, 1'b0);
        cs_begin();
        send_nib(32'h0, 3);
        cs_end();
        fast_read(24'h000077, 2, 0);
        check_bytes(119, 2, "R6 abort before flag leaves continuous mode");
    endtask

    initial begin
        t_reset();
        t_fast();
        t_mask();
        t_busy();
        t_quad_out(24'h000020, 1'b1);
        fast_read(24'h000021, 2, 0);
        check_bytes(33, 2, "R6 flag 1 returns to command decoding R2");
        t_quad_io(24'h000080, 1'b0);
        t_xip(24'h0000C0, 1'b0);
        t_xip(24'h1234F0, 1'b1);
        fast_read(24'h000003, 2, 0);
        check_bytes(3, 2, "R6 continuous exit on flag 1");
        t_quad_out(24'h0000A0, 1'b0);
        t_xip(24'h0000FE, 1'b1);
        t_invalid();
        t_abort_xip();
        summary();
        $finish;
    end
endmodule